// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Software Refill

This block translates virtual addresses to physical addresses through a small, fully associative table of page translations. System software fills the table. The only state outside the table is a register that holds the identifier of the address space now running. Each lookup compares the upper address bits with every entry at once. An entry takes part in the match only when its address-space tag equals the current identifier, or when the entry is marked global. The 12-bit page offset bypasses translation.

A lookup that finds no entry raises a refill exception, and software walks its own page tables. A lookup that finds an entry can still fail in two ways: the entry is marked not valid, or a store reaches a page that is not writable. Any exception latches the full faulting virtual address, so the handler can read it. Software writes whole entries at an index it chooses. The hardware has no replacement policy.

Lookups are combinational against the stored entries, and the result is registered, so the response appears one cycle after the request.

Top module: `asid_tlb`

## Requirements
- R1: After reset, `rsp_valid` is 0, `rsp_exc` is 0, `bad_vaddr` is 0, the current address-space identifier is 0 and every entry has its valid flag cleared.
- R2: A request on `req_valid` produces exactly one cycle of `rsp_valid` on the next cycle. On a hit with no exception, `rsp_paddr` is the entry's frame number joined to `req_vaddr[11:0]`, and `rsp_exc` is 0.
- R3: An entry matches only when its page number equals `req_vaddr[31:12]` and either its tag equals the current identifier (set through `asid_set`/`asid_val`) or its global bit is 1.
- R4: When no entry matches, `rsp_exc` is 1 (refill).
- R5: When the matched entry has its valid flag at 0, `rsp_exc` is 2 (invalid). This takes precedence over the write check.
- R6: A store (`req_type` = 2) that hits a valid entry with the writable flag at 0 gives `rsp_exc` = 3 (modify). Fetches (`req_type` = 0) and loads (`req_type` = 1) ignore the writable flag.
- R7: Any exception loads `bad_vaddr` with the whole `req_vaddr` of that request. In all other cycles `bad_vaddr` keeps its value.
- R8: On a clean hit, `rsp_cacheable` is the inverse of the entry's no-cache flag. When an exception is reported, `rsp_cacheable` and `rsp_paddr` are 0.
- R9: An entry write or an identifier change takes effect for lookups issued in the following cycle. A lookup issued in the same cycle as a write sees the old contents.
- R10: If several entries match, the entry with the lowest index supplies the translation.
- R11: With no request, `rsp_valid` is 0 and `rsp_exc` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| asid_set | input | 1 | Load the current address-space identifier |
| asid_val | input | 8 | New identifier value |
| wr_en | input | 1 | Write an entry |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 8 | Address-space tag to store |
| wr_global | input | 1 | Ignore the tag when matching |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_nocache | input | 1 | 1 marks the page not cacheable |
| wr_writable | input | 1 | 1 allows stores |
| wr_valid | input | 1 | 1 marks the entry usable |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_type | input | 2 | 0 fetch, 1 load, 2 store |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_cacheable | output | 1 | Access may use the cache |
| rsp_exc | output | 2 | 0 none, 1 refill, 2 invalid, 3 modify |
| bad_vaddr | output | 32 | Last faulting virtual address |

## Verification
The assertions check on every cycle the relations that hold whatever the table holds. A response follows each request and only a request. The offset passes through unchanged. A fault latches the address, and `bad_vaddr` holds when there is no fault. Fetches and loads never raise a modify fault. A faulted response carries neither an address nor cacheability. The bench scenarios are the only way to show which exception a given table content produces: tag and global matching, refill versus invalid versus modify precedence, the exact frame substituted, the no-cache flag, lowest-index selection, and the one-cycle visibility of writes.

// File: rtl/tlb_pkg.sv
// Shared widths, entry layout and code values for the translation buffer.
// Assumes 32-bit virtual and physical addresses with 4 KiB pages.
package tlb_pkg;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = 20;
    localparam int PFN_W    = 20;
    localparam int ASID_W   = 8;
    localparam int VA_W     = VPN_W + OFF_W;
    localparam int PA_W     = PFN_W + OFF_W;
    localparam int N_ENTRY  = 16;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              global_pg;
        logic [PFN_W-1:0]  pfn;
        logic              nocache;
        logic              writable;
        logic              valid;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_REFILL  = 2'd1,
        EXC_INVALID = 2'd2,
        EXC_MODIFY  = 2'd3
    } exc_e;
endpackage

// File: rtl/tlb_entry_array.sv
// Entry storage with one write port and a per-entry tag comparator.
// Assumes at most one write per cycle; a write is seen by compares next cycle.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = N_ENTRY,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  tlb_entry_t             wr_entry,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [ASID_W-1:0]      cur_asid,
    output logic [ENTRIES-1:0]     match_vec,
    output tlb_entry_t             entry_q [ENTRIES]
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Hold one entry; reset leaves it cleared and not valid.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                entry_q[i] <= wr_entry;
        end

        // Page number must agree; tag must agree unless the page is global.
        always_comb begin
            match_vec[i] = (entry_q[i].vpn == lk_vpn) &&
                           (entry_q[i].global_pg || entry_q[i].asid == cur_asid);
        end
    end
endmodule

// File: rtl/tlb_select.sv
// Reduces the match vector to one entry, lowest index first.
// Assumes software normally keeps at most one matching entry.
module tlb_select
    import tlb_pkg::*;
#(
    parameter int ENTRIES = N_ENTRY
) (
    input  logic [ENTRIES-1:0] match_vec,
    input  tlb_entry_t         entry_q [ENTRIES],
    output logic               hit,
    output tlb_entry_t         sel_entry
);
    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        hit       = |match_vec;
        sel_entry = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i])
                sel_entry = entry_q[i];
        end
    end
endmodule

// File: rtl/asid_tlb.sv
// Top of the software-refilled translation buffer: identifier register,
// exception decode in priority refill > invalid > modify, registered result.
// Assumes the requester samples the response one cycle after the request.
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = N_ENTRY,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                asid_set,
    input  logic [ASID_W-1:0]   asid_val,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [VPN_W-1:0]    wr_vpn,
    input  logic [ASID_W-1:0]   wr_asid,
    input  logic                wr_global,
    input  logic [PFN_W-1:0]    wr_pfn,
    input  logic                wr_nocache,
    input  logic                wr_writable,
    input  logic                wr_valid,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [1:0]          req_type,
    output logic                rsp_valid,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic                rsp_cacheable,
    output logic [1:0]          rsp_exc,
    output logic [VA_W-1:0]     bad_vaddr
);
    logic [ASID_W-1:0]  asid_q;
    tlb_entry_t         wr_entry;
    logic [ENTRIES-1:0] match_vec;
    tlb_entry_t         entry_q [ENTRIES];
    logic               hit;
    tlb_entry_t         sel;
    exc_e               exc_d;

    // Pack the write fields into one entry.
    always_comb begin
        wr_entry = '{vpn: wr_vpn, asid: wr_asid, global_pg: wr_global,
                     pfn: wr_pfn, nocache: wr_nocache,
                     writable: wr_writable, valid: wr_valid};
    end

    // Current address-space identifier.
    always_ff @(posedge clk) begin
        if (!rst_n)
            asid_q <= '0;
        else if (asid_set)
            asid_q <= asid_val;
    end

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_entry  (wr_entry),
        .lk_vpn    (req_vaddr[VA_W-1:OFF_W]),
        .cur_asid  (asid_q),
        .match_vec (match_vec),
        .entry_q   (entry_q)
    );

    tlb_select #(.ENTRIES(ENTRIES)) u_select (
        .match_vec (match_vec),
        .entry_q   (entry_q),
        .hit       (hit),
        .sel_entry (sel)
    );

    // Pick a single exception cause in fixed priority.
    always_comb begin
        if (!hit)
            exc_d = EXC_REFILL;
        else if (!sel.valid)
            exc_d = EXC_INVALID;
        else if (req_type == ACC_STORE && !sel.writable)
            exc_d = EXC_MODIFY;
        else
            exc_d = EXC_NONE;
    end

    // Register the response; faults clear address and cacheability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_cacheable <= 1'b0;
            rsp_exc       <= EXC_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid && exc_d == EXC_NONE) begin
                rsp_paddr     <= {sel.pfn, req_vaddr[OFF_W-1:0]};
                rsp_cacheable <= ~sel.nocache;
                rsp_exc       <= EXC_NONE;
            end else begin
                rsp_paddr     <= '0;
                rsp_cacheable <= 1'b0;
                rsp_exc       <= req_valid ? exc_d : EXC_NONE;
            end
        end
    end

    // Capture the faulting address on any exception.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bad_vaddr <= '0;
        else if (req_valid && exc_d != EXC_NONE)
            bad_vaddr <= req_vaddr;
    end
endmodule

// File: rtl/asid_tlb_chk.sv
// Cycle-level properties of the translation buffer, attached by bind.
// Observes only ports of the top module.
module asid_tlb_chk
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic [1:0]        req_type,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              rsp_cacheable,
    input logic [1:0]        rsp_exc,
    input logic [VA_W-1:0]   bad_vaddr
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_exc == 2'd0)); // R11
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_exc != 2'd0 ||
                       rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R2
    AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_exc == 2'd0 || bad_vaddr == $past(req_vaddr))); // R7
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(bad_vaddr)); // R7
    AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_exc != 2'd0 || $stable(bad_vaddr))); // R7
    AST_NO_MODIFY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type != 2'd2) |=> rsp_exc != 2'd3); // R6
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc != 2'd0 |-> (!rsp_cacheable && rsp_paddr == '0)); // R8
endmodule

bind asid_tlb asid_tlb_chk u_chk (.*);

// File: tb/tb_asid_tlb.sv
// Directed bench for asid_tlb: one task per scenario, each checks itself.
module tb_asid_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        asid_set = 1'b0;
    logic [7:0]  asid_val = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn = '0;
    logic        wr_nocache = 1'b0;
    logic        wr_writable = 1'b0;
    logic        wr_valid = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_type = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_cacheable;
    logic [1:0]  rsp_exc;
    logic [31:0] bad_vaddr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    asid_tlb dut (.*);

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_asid(logic [7:0] a);
        @(negedge clk);
        asid_set = 1'b1; asid_val = a;
        @(negedge clk);
        asid_set = 1'b0;
    endtask

    task automatic put(logic [3:0] idx, logic [19:0] vpn, logic [7:0] asid, logic g,
                       logic [19:0] pfn, logic nc, logic wrt, logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_global = g;
        wr_pfn = pfn; wr_nocache = nc; wr_writable = wrt; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one lookup; outputs are sampled at the next falling edge.
    task automatic look(logic [31:0] va, logic [1:0] t);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_type = t;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 rsp_exc", 32'(rsp_exc), 32'd0);
        check("R1 bad_vaddr", bad_vaddr, 32'd0);
        // Reset entries are invalid with tag 0 and page 0.
        look(32'h0000_0123, 2'd1);
        check("R1 reset entry invalid", 32'(rsp_exc), 32'd2);
    endtask

    task automatic t_hit;
        set_asid(8'h05);
        put(4'd0, 20'h12345, 8'h05, 1'b0, 20'hABCDE, 1'b0, 1'b1, 1'b1);
        put(4'd1, 20'h00011, 8'h05, 1'b0, 20'h00022, 1'b1, 1'b1, 1'b1);
        look(32'h1234_5678, 2'd1);
        check("R2 rsp_valid", 32'(rsp_valid), 32'd1);
        check("R2 paddr", rsp_paddr, 32'hABCD_E678);
        check("R2 exc", 32'(rsp_exc), 32'd0);
        check("R8 cacheable", 32'(rsp_cacheable), 32'd1);
        look(32'h0001_1FFF, 2'd2);
        check("R2 paddr nc", rsp_paddr, 32'h0002_2FFF);
        check("R8 nocache", 32'(rsp_cacheable), 32'd0);
        @(negedge clk);
        check("R11 idle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_asid;
        set_asid(8'h06);
        look(32'h1234_5678, 2'd0);
        check("R3 tag mismatch", 32'(rsp_exc), 32'd0 + 32'd1);
        check("R4 refill", 32'(rsp_exc), 32'd1);
        check("R7 bad_vaddr refill", bad_vaddr, 32'h1234_5678);
        check("R8 fault paddr", rsp_paddr, 32'd0);
        put(4'd2, 20'h40000, 8'h33, 1'b1, 20'h55555, 1'b0, 1'b1, 1'b1);
        look(32'h4000_0ABC, 2'd1);
        check("R3 global hit", rsp_paddr, 32'h5555_5ABC);
        check("R7 hold on hit", bad_vaddr, 32'h1234_5678);
    endtask

    task automatic t_faults;
        put(4'd3, 20'h70000, 8'h06, 1'b0, 20'h00333, 1'b0, 1'b0, 1'b0);
        put(4'd4, 20'h71000, 8'h06, 1'b0, 20'h00444, 1'b0, 1'b0, 1'b1);
        look(32'h7000_0010, 2'd2);
        check("R5 invalid over modify", 32'(rsp_exc), 32'd2);
        check("R7 bad_vaddr invalid", bad_vaddr, 32'h7000_0010);
        look(32'h7100_0020, 2'd2);
        check("R6 modify", 32'(rsp_exc), 32'd3);
        check("R7 bad_vaddr modify", bad_vaddr, 32'h7100_0020);
        check("R8 fault cacheable", 32'(rsp_cacheable), 32'd0);
        look(32'h7100_0030, 2'd1);
        check("R6 load readonly", 32'(rsp_exc), 32'd0);
        check("R6 load paddr", rsp_paddr, 32'h0044_4030);
        look(32'h7100_0040, 2'd0);
        check("R6 fetch readonly", 32'(rsp_exc), 32'd0);
        check("R7 hold after load", bad_vaddr, 32'h7100_0020);
    endtask

    task automatic t_write_timing;
        put(4'd5, 20'h72000, 8'h06, 1'b0, 20'h00001, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd5; wr_vpn = 20'h72000; wr_asid = 8'h06;
        wr_global = 1'b0; wr_pfn = 20'h00002; wr_nocache = 1'b0;
        wr_writable = 1'b1; wr_valid = 1'b1;
        req_valid = 1'b1; req_vaddr = 32'h7200_0004; req_type = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R9 same-cycle old", rsp_paddr, 32'h0000_1004);
        look(32'h7200_0004, 2'd1);
        check("R9 next-cycle new", rsp_paddr, 32'h0000_2004);
    endtask

    task automatic t_lowest;
        put(4'd9, 20'h73000, 8'h00, 1'b1, 20'h00009, 1'b0, 1'b1, 1'b1);
        put(4'd7, 20'h73000, 8'h00, 1'b1, 20'h00007, 1'b0, 1'b1, 1'b1);
        look(32'h7300_0100, 2'd1);
        check("R10 lowest index", rsp_paddr, 32'h0000_7100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_asid();
        t_faults();
        t_write_timing();
        t_lowest();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule